// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This block watches an asynchronous hot-plug-detect line from a display connector. The line first passes through a two-stage synchroniser. A debounce filter then decides the settled level. Each settled transition raises its own sticky event bit, one for a rising edge and one for a falling edge. These two events are merged with the level of an interrupt coming from a neighbouring controller core, and the result drives one registered interrupt line.

Software reaches five word locations through a simple synchronous register port:

| Address | Contents |
|---|---|
| 0 | Settled level (read only) |
| 1 | Event status (read only) |
| 2 | Write-one-to-clear strobe |
| 3 | Enable mask, where 1 means enabled |
| 4 | Debounce setting |

The debounce setting holds a step count in its low byte and a prescale in bits 15:12. The settled level follows the synchronised input only after a difference has lasted (prescale+1)·(count+1) consecutive cycles.

A typical driver programs the filter, clears any stale edge events, and then enables the sources it wants.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset, the level reads 0, the status reads 0, the mask reads 0, the filter reads 0xA0A0, and irq_out is 0.
- R2: The level register (address 0, bit 0) changes to the new input value after the input has held that value for 2+(P+1)·(C+1) clock edges, where P = filter[15:12] and C = filter[7:0]. It has not changed one edge earlier. With the reset filter setting this is 2+11·161 edges.
- R3: An input excursion shorter than the filter window changes neither the level nor the status.
- R4: Status bit 1 is set when the settled level goes 0→1, and status bit 2 is set when it goes 1→0. Both bits stay set until cleared, and both can be pending at the same time.
- R5: Writing to address 2 clears each status bit 1 or 2 whose written bit is 1. Bits written as 0 are left unchanged. Writing to bit 0 has no effect.
- R6: When a clear write and a new edge event hit the same status bit in the same cycle, the bit ends up set.
- R7: Status bit 0 equals core_irq as sampled at the previous clock edge.
- R8: irq_out is the OR over the three bits of (status AND mask), registered, so it lags the status and mask by one edge.
- R9: The mask (bits 2:0 at address 3) and the filter (address 4) read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd_in | input | 1 | Asynchronous hot-plug-detect line |
| core_irq | input | 1 | Interrupt level from the neighbouring core |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq_out | output | 1 | Registered interrupt output |

## Verification
Each result arrives a fixed number of edges after its stimulus:

- **Settled level and edge events:** 2+(P+1)·(C+1) edges after the input changes (two synchroniser stages plus the filter window).
- **Status bit 0:** one edge after core_irq changes.
- **irq_out:** one edge after the status or mask changes.
- **Register writes:** visible on the edge that takes the strobe.

The bench drives inputs on falling edges and counts rising edges from that point. It checks each result at the falling edge just before its due edge, where the old value must still be present, and again just after it. The same-cycle race between a clear and an event is produced by timing the clear strobe to land on the computed filter-completion edge.

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 4,
  parameter int PRE_LSB   = 12,
  parameter logic [15:0] FILT_RST = 16'hA0A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpd_in,
  input  logic              core_irq,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int SRC_N = 3;
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FILT  = ADDR_W'(4);

  logic [1:0]        sync_q;
  logic              level_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] filt_q;
  logic [SRC_N-1:0]  mask_q;
  logic [SRC_N-1:0]  stat_q;
  logic              irq_q;

  wire [PRE_W-1:0] presc = filt_q[PRE_LSB +: PRE_W];
  wire [CNT_W-1:0] steps = filt_q[CNT_W-1:0];
  wire diff    = sync_q[1] ^ level_q;
  wire pre_hit = (pre_q == presc);
  wire flip    = diff & pre_hit & (cnt_q == steps);

  wire wr_clr  = reg_wr_en && (reg_addr == A_CLR);
  wire wr_mask = reg_wr_en && (reg_addr == A_MASK);
  wire wr_filt = reg_wr_en && (reg_addr == A_FILT);
  wire [SRC_N-1:0] clr_bits = wr_clr ? reg_wdata[SRC_N-1:0] : '0;

  wire set_rise = flip &  sync_q[1];
  wire set_fall = flip & ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], hpd_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else if (!diff) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_hit) begin
      pre_q <= '0;
      if (flip) begin
        cnt_q   <= '0;
        level_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= DATA_W'(FILT_RST);
      mask_q <= '0;
    end else begin
      if (wr_filt) filt_q <= reg_wdata;
      if (wr_mask) mask_q <= reg_wdata[SRC_N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q[0] <= core_irq;
      stat_q[1] <= set_rise | (stat_q[1] & ~clr_bits[1]);
      stat_q[2] <= set_fall | (stat_q[2] & ~clr_bits[2]);
      irq_q     <= |(stat_q & mask_q);
    end
  end

  assign irq_out = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LEVEL: reg_rdata[0] = level_q;
      A_STAT:  reg_rdata[SRC_N-1:0] = stat_q;
      A_MASK:  reg_rdata[SRC_N-1:0] = mask_q;
      A_FILT:  reg_rdata = filt_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hpd_irq_unit_chk.sv
module hpd_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       core_irq,
  input logic       sync_in,
  input logic       level,
  input logic [2:0] status,
  input logic [2:0] mask,
  input logic       irq_out
);
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == |($past(status) & $past(mask))));

  // R4
  rise_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |-> status[1]);

  // R4
  fall_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level) |-> status[2]);

  // R2
  level_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> (level == $past(sync_in)));

  // R3
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $rose(level));

  // R3
  fall_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $fell(level));

  // R7
  core_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |=> status[0]);
endmodule

bind hpd_irq_unit hpd_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_irq(core_irq), .sync_in(sync_q[1]),
  .level(level_q), .status(stat_q), .mask(mask_q), .irq_out(irq_out)
);

// File: tb/hpd_irq_unit_tb.sv
`timescale 1ns/1ps
module hpd_irq_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hpd_in = 1'b0;
  logic core_irq = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hpd_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .hpd_in(hpd_in), .core_irq(core_irq),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(string req, logic [2:0] a, logic [15:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic write_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic edge_and_check(bit v, int win, string req);
    @(negedge clk);
    hpd_in = v;
    repeat (1 + win) @(posedge clk);
    @(negedge clk);
    read_chk({req, " early"}, 3'd0, {15'd0, ~v});
    @(posedge clk);
    @(negedge clk);
    read_chk({req, " due"}, 3'd0, {15'd0, v});
  endtask

  task automatic t_reset();
    read_chk("R1 level", 3'd0, 16'h0);
    read_chk("R1 status", 3'd1, 16'h0);
    read_chk("R1 mask", 3'd3, 16'h0);
    read_chk("R1 filter", 3'd4, 16'hA0A0);
    check("R1 irq", {15'd0, irq_out}, 16'h0);
  endtask

  task automatic t_default_rise();
    edge_and_check(1'b1, 11 * 161, "R2 default window");
    read_chk("R4 rise latched", 3'd1, 16'h0002);
  endtask

  task automatic t_regs();
    write_reg(3'd4, 16'h1002);
    read_chk("R9 filter readback", 3'd4, 16'h1002);
    write_reg(3'd3, 16'h0005);
    read_chk("R9 mask readback", 3'd3, 16'h0005);
    write_reg(3'd3, 16'h0000);
  endtask

  task automatic t_clear();
    write_reg(3'd2, 16'h0001);
    read_chk("R5 bit0 write no effect", 3'd1, 16'h0002);
    write_reg(3'd2, 16'h0004);
    read_chk("R5 zero bit kept", 3'd1, 16'h0002);
    write_reg(3'd2, 16'h0002);
    read_chk("R5 rise cleared", 3'd1, 16'h0000);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    hpd_in = 1'b0;
    repeat (4) @(negedge clk);
    hpd_in = 1'b1;
    repeat (20) @(negedge clk);
    read_chk("R3 level held", 3'd0, 16'h0001);
    read_chk("R3 no event", 3'd1, 16'h0000);
  endtask

  task automatic t_both();
    edge_and_check(1'b0, 6, "R2 fall window");
    read_chk("R4 fall latched", 3'd1, 16'h0004);
    edge_and_check(1'b1, 6, "R2 rise window");
    read_chk("R4 both pending", 3'd1, 16'h0006);
  endtask

  task automatic t_mask_irq();
    write_reg(3'd3, 16'h0002);
    check("R8 irq lags mask", {15'd0, irq_out}, 16'h0);
    @(posedge clk);
    @(negedge clk);
    check("R8 irq asserted", {15'd0, irq_out}, 16'h1);
    write_reg(3'd2, 16'h0002);
    @(posedge clk);
    @(negedge clk);
    check("R8 irq dropped, fall unmasked", {15'd0, irq_out}, 16'h0);
  endtask

  task automatic t_core();
    write_reg(3'd3, 16'h0001);
    @(negedge clk);
    core_irq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    read_chk("R7 core mirrored", 3'd1, 16'h0005);
    check("R8 irq one edge later", {15'd0, irq_out}, 16'h0);
    @(posedge clk);
    @(negedge clk);
    check("R8 core irq out", {15'd0, irq_out}, 16'h1);
    write_reg(3'd2, 16'h0001);
    read_chk("R5 core bit not clearable", 3'd1, 16'h0005);
    @(negedge clk);
    core_irq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    read_chk("R7 core low mirrored", 3'd1, 16'h0004);
    write_reg(3'd2, 16'h0006);
    read_chk("R5 all cleared", 3'd1, 16'h0000);
  endtask

  task automatic t_race();
    @(negedge clk);
    hpd_in = 1'b0;
    repeat (1 + 6) @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0004;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    read_chk("R6 level fell", 3'd0, 16'h0000);
    read_chk("R6 event beats clear", 3'd1, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_rise();
    t_regs();
    t_clear();
    t_glitch();
    t_both();
    t_mask_irq();
    t_core();
    t_race();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule